// File: doc/BRIEF.md
# SD/MMC Host Interrupt Flag and Mask Unit

This unit gathers the interrupt sources of an SD/MMC host controller into one 8-bit flag register. Four sources are single-cycle event pulses: command response finished, data transfer finished, card programming finished, and the card's own interrupt. Each pulse sets a sticky flag, and the flag stays set until software clears it. Two more flags are FIFO service requests. They are computed from the fill levels of the receive and transmit data FIFOs and track those levels continuously.

A separate mask register gates each flag onto the single interrupt line. A mask bit of 1 blocks its source. The mask comes out of reset with every bit set, so no interrupt can reach the host until software opens it. Software uses one write port with a register select. On the flag register, a write clears every event flag whose data bit is 1. On the mask register, a write loads the new mask value.

Top module: `sdhost_irq_flags`

## Requirements
- R1: While reset is asserted, the flag register reads 0x00, the mask reads 0xFF and the interrupt line is low.
- R2: A pulse on an event input sets its flag on the next clock edge, and the flag then holds. The flag positions are: bit 0 transfer done, bit 1 programming done, bit 2 command response done, bit 7 card interrupt.
- R3: A write with `wr_sel`=0 clears each event flag (bits 0, 1, 2, 7) whose `wr_data` bit is 1. Writing 0xFF clears all of them.
- R4: If an event pulse and a clear of the same flag occur in one cycle, the flag ends up set.
- R5: Bit 5 (receive read request) reads 1 one cycle after `rx_words` is 8 or more, and reads 0 one cycle after it is less than 8.
- R6: Bit 6 (transmit write request) reads 1 one cycle after `tx_words` is less than 8, and reads 0 one cycle after it is 8 or more.
- R7: Writes to the flag register do not change bits 5 and 6. Bits 3 and 4 always read 0.
- R8: A write with `wr_sel`=1 loads `wr_data` into the mask on the next edge.
- R9: `irq` is high exactly when some flag bit is 1 and the mask bit at the same position is 0. Flags are set whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: flag register (write-one-to-clear), 1: mask register |
| wr_data | input | 8 | Write data |
| ev_xfer_done | input | 1 | Data transfer finished pulse |
| ev_prog_done | input | 1 | Card programming finished pulse |
| ev_cmd_resp | input | 1 | Command response finished pulse |
| ev_card_irq | input | 1 | Card interrupt pulse |
| rx_words | input | 5 | Words held in the receive FIFO |
| tx_words | input | 5 | Words held in the transmit FIFO |
| flags_rd | output | 8 | Flag register |
| mask_rd | output | 8 | Mask register |
| irq | output | 1 | Interrupt line |

## Verification
The collision that matters is an event pulse and a software clear of the same flag landing on one clock edge. Directed cycles drive the pulse together with a clear write that has the matching data bit set. The flag must read 1 afterwards. The random phase mixes pulses and clear writes freely, and a bench model checks every cycle that the set wins.

A second collision is a flag-register write that targets the FIFO request bits while those bits are asserted. The bits must still follow the FIFO levels after the write.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;
    localparam int FLAG_W      = 8;
    localparam int POS_XFER    = 0;
    localparam int POS_PROG    = 1;
    localparam int POS_CMD     = 2;
    localparam int POS_RXREQ   = 5;
    localparam int POS_TXREQ   = 6;
    localparam int POS_CARD    = 7;
    localparam int N_EVT       = 4;
    localparam int EVT_POS [N_EVT] = '{POS_XFER, POS_PROG, POS_CMD, POS_CARD};
endpackage

// File: rtl/sdirq_evt_bank.sv
module sdirq_evt_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_pulse,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] evt_q
);
    typedef struct packed {
        logic [N-1:0] evt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (clr_en && clr_bits[i]) st_d.evt[i] = 1'b0;
            if (evt_pulse[i])          st_d.evt[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_q = st_q.evt;

    a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != '0) |=> ((evt_q & $past(evt_pulse)) == $past(evt_pulse)));
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((evt_q & $past(clr_bits & ~evt_pulse)) == '0));
    a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en && evt_pulse == '0) |=> $stable(evt_q));
endmodule

// File: rtl/sdirq_fifo_req.sv
module sdirq_fifo_req #(
    parameter int LVL_W  = 5,
    parameter int THRESH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    output logic             rx_req_q,
    output logic             tx_req_q
);
    localparam logic [LVL_W-1:0] THR = LVL_W'(THRESH);

    typedef struct packed {
        logic rx;
        logic tx;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.rx = (rx_level >= THR);
        st_d.tx = (tx_level <  THR);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_req_q = st_q.rx;
    assign tx_req_q = st_q.tx;

    a_r5_rx_req: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level >= THR) |=> rx_req_q);
    a_r6_tx_req: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level >= THR) |=> !tx_req_q);
endmodule

// File: rtl/sdirq_mask_reg.sv
module sdirq_mask_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] mask_q
);
    typedef struct packed {
        logic [W-1:0] mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) st_d.mask = ld_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign mask_q = st_q.mask;

    a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (mask_q == $past(ld_val)));
endmodule

// File: rtl/sdhost_irq_flags.sv
module sdhost_irq_flags
    import sdirq_pkg::*;
#(
    parameter int LVL_W  = 5,
    parameter int THRESH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [FLAG_W-1:0] wr_data,
    input  logic              ev_xfer_done,
    input  logic              ev_prog_done,
    input  logic              ev_cmd_resp,
    input  logic              ev_card_irq,
    input  logic [LVL_W-1:0]  rx_words,
    input  logic [LVL_W-1:0]  tx_words,
    output logic [FLAG_W-1:0] flags_rd,
    output logic [FLAG_W-1:0] mask_rd,
    output logic              irq
);
    logic [N_EVT-1:0] evt_in, evt_clr, evt_q;
    logic             rx_req, tx_req;

    assign evt_in = {ev_card_irq, ev_cmd_resp, ev_prog_done, ev_xfer_done};

    for (genvar g = 0; g < N_EVT; g++) begin : g_clr
        assign evt_clr[g] = wr_data[EVT_POS[g]];
    end

    sdirq_evt_bank #(.N(N_EVT)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_in),
        .clr_en    (wr_en && !wr_sel),
        .clr_bits  (evt_clr),
        .evt_q     (evt_q)
    );

    sdirq_fifo_req #(.LVL_W(LVL_W), .THRESH(THRESH)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_level (rx_words),
        .tx_level (tx_words),
        .rx_req_q (rx_req),
        .tx_req_q (tx_req)
    );

    sdirq_mask_reg #(.W(FLAG_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (wr_en && wr_sel),
        .ld_val (wr_data),
        .mask_q (mask_rd)
    );

    always_comb begin
        flags_rd = '0;
        for (int i = 0; i < N_EVT; i++) flags_rd[EVT_POS[i]] = evt_q[i];
        flags_rd[POS_RXREQ] = rx_req;
        flags_rd[POS_TXREQ] = tx_req;
    end

    assign irq = |(flags_rd & ~mask_rd);

    a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flags_rd[4:3] == 2'b00);
    a_r9_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rd == '1) |-> !irq);
    a_r9_set_under_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_card_irq && mask_rd[POS_CARD]) |=> flags_rd[POS_CARD]);
endmodule

// File: tb/sdhost_irq_flags_test.sv
module sdhost_irq_flags_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [3:0] ev = '0;
    logic [4:0] rx_words = '0, tx_words = 5'd16;
    logic [7:0] flags_rd, mask_rd;
    logic       irq;
    int         n_run = 0, n_fail = 0;
    logic [7:0] m_flags = 8'h00, m_mask = 8'hFF;

    always #4 clk = ~clk;

    sdhost_irq_flags uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ev_xfer_done(ev[0]), .ev_prog_done(ev[1]), .ev_cmd_resp(ev[2]), .ev_card_irq(ev[3]),
        .rx_words(rx_words), .tx_words(tx_words),
        .flags_rd(flags_rd), .mask_rd(mask_rd), .irq(irq)
    );

    function automatic logic [7:0] f_next(logic [7:0] cur, logic w, logic s, logic [7:0] d,
                                          logic [3:0] e, logic [4:0] rxl, logic [4:0] txl);
        logic [7:0] n;
        logic [7:0] setm;
        setm = {e[3], 4'b0000, e[2], e[1], e[0]};
        n = cur & 8'h87;
        if (w && !s) n = n & ~d;
        n = (n | setm) & 8'h87;
        n[5] = (rxl >= 5'd8);
        n[6] = (txl <  5'd8);
        return n;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(logic w, logic s, logic [7:0] d, logic [3:0] e, logic [4:0] rxl, logic [4:0] txl);
        wr_en = w; wr_sel = s; wr_data = d; ev = e; rx_words = rxl; tx_words = txl;
        @(negedge clk);
        m_flags = f_next(m_flags, w, s, d, e, rxl, txl);
        if (w && s) m_mask = d;
        wr_en = 1'b0; ev = '0;
    endtask

    task automatic chk_all(string tag);
        chk(tag, {24'd0, flags_rd}, {24'd0, m_flags});
        chk(tag, {24'd0, mask_rd},  {24'd0, m_mask});
        chk(tag, {31'd0, irq},      {31'd0, |(m_flags & ~m_mask)});
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1 flags in reset", {24'd0, flags_rd}, 32'h00);
        chk("R1 mask in reset",  {24'd0, mask_rd},  32'hFF);
        chk("R1 irq in reset",   {31'd0, irq},      32'd0);
        rst_n = 1'b1;
        cyc(0, 0, 8'h00, 4'b0000, 5'd0, 5'd16);
        chk("R1 R6 after reset", {24'd0, flags_rd}, 32'h00);

        cyc(0, 0, 8'h00, 4'b0000, 5'd7, 5'd8);
        chk("R5 rx 7 no request", {31'd0, flags_rd[5]}, 32'd0);
        chk("R6 tx 8 no request", {31'd0, flags_rd[6]}, 32'd0);
        cyc(0, 0, 8'h00, 4'b0000, 5'd8, 5'd7);
        chk("R5 rx 8 request", {31'd0, flags_rd[5]}, 32'd1);
        chk("R6 tx 7 request", {31'd0, flags_rd[6]}, 32'd1);

        cyc(1, 0, 8'h78, 4'b0000, 5'd8, 5'd7);
        chk("R7 write to request bits ignored", {24'd0, flags_rd}, 32'h60);
        chk("R7 bits 3 4 read zero", {30'd0, flags_rd[4:3]}, 32'd0);

        cyc(0, 0, 8'h00, 4'b0100, 5'd0, 5'd16);
        chk("R2 cmd pulse sets bit2", {24'd0, flags_rd}, 32'h04);
        cyc(0, 0, 8'h00, 4'b0000, 5'd0, 5'd16);
        chk("R2 flag holds", {24'd0, flags_rd}, 32'h04);
        chk("R9 masked flag no irq", {31'd0, irq}, 32'd0);

        cyc(1, 1, 8'hFB, 4'b0000, 5'd0, 5'd16);
        chk("R8 mask loaded", {24'd0, mask_rd}, 32'hFB);
        chk("R9 unmasked flag raises irq", {31'd0, irq}, 32'd1);

        cyc(1, 0, 8'h04, 4'b0000, 5'd0, 5'd16);
        chk("R3 w1c bit2", {24'd0, flags_rd}, 32'h00);
        chk("R9 irq drops", {31'd0, irq}, 32'd0);

        cyc(0, 0, 8'h00, 4'b1111, 5'd0, 5'd16);
        chk("R2 all events set", {24'd0, flags_rd}, 32'h87);
        cyc(1, 0, 8'h02, 4'b0010, 5'd0, 5'd16);
        chk("R4 set wins over clear", {24'd0, flags_rd}, 32'h87);
        cyc(1, 0, 8'hFF, 4'b0000, 5'd0, 5'd16);
        chk("R3 write FF clears all", {24'd0, flags_rd}, 32'h00);

        cyc(1, 1, 8'hFF, 4'b1000, 5'd0, 5'd16);
        chk("R9 card flag set while masked", {24'd0, flags_rd}, 32'h80);
        chk("R9 all masked no irq", {31'd0, irq}, 32'd0);

        for (int k = 0; k < 3000; k++) begin
            logic w, s;
            logic [7:0] d;
            logic [3:0] e;
            w = ($urandom % 4) == 0;
            s = ($urandom % 3) == 0;
            d = 8'($urandom);
            e = 4'($urandom) & 4'($urandom);
            cyc(w, s, d, e, 5'($urandom % 17), 5'($urandom % 17));
            chk_all("R2 R3 R4 R5 R6 R7 R8 R9 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule